// File: doc/BRIEF.md
# Dual-Role Bus Tenure Controller

This block decides who owns a shared external bus on behalf of one on-chip master. Three active-low handshake lines are involved: request, grant and busy. A static mode input sets the role. In arbiter role the block sees request as an input from a single outside master, drives grant back to it, and drives busy low while the local master holds the bus. In requester role the block drives request toward an outside arbiter, samples grant, and drives busy once it has taken the bus.

In both roles a grant counts only when the busy line is high at the same sampled edge. The local master raises `loc_req_i` and holds it. It waits for `loc_own_o`, runs its transfer, and then pulses `loc_done_i`. The block releases busy one cycle later. It starts no new tenure until busy has been sampled high at a clock edge.

Every line is sampled, and every output changes, only on the rising edge of `clk_i`. A change of mode takes effect through reset.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: While `rst_ni` is low, `loc_own_o`=0, `arb_req_n_o`=1, `arb_gnt_n_o`=1, `arb_bsy_n_o`=1 and `arb_bsy_oe_o`=0.
- R2: With `mode_ext_i`=0 (arbiter role), `arb_gnt_oe_o`=1 and `arb_req_oe_o`=0. With `mode_ext_i`=1 (requester role), `arb_gnt_oe_o`=0 and `arb_req_oe_o`=1.
- R3: Arbiter role: at the edge that samples `loc_req_i`=1 with the bus parked and no external request, `loc_own_o` rises, `arb_bsy_n_o` falls and `arb_bsy_oe_o` rises.
- R4: Arbiter role: at the edge that samples `arb_req_n_i`=0 with the bus parked and no local request, `arb_gnt_n_o` falls. The grant stays low until an edge samples `arb_bsy_n_i`=0, and it rises at that edge. If the request returns high first, the grant rises at the edge that samples the withdrawal.
- R5: Arbiter role: when both masters request at the same edge, the local master gets the bus. At the next arbitration edge where both request again, the external master gets the grant.
- R6: At the edge that samples `loc_done_i`=1 during local ownership, `loc_own_o` falls and `arb_bsy_n_o` returns high, while `arb_bsy_oe_o` stays high for one more cycle. No grant and no new ownership comes before the second edge after that.
- R7: Arbiter role: after the external master has taken the bus, neither a grant nor local ownership follows until an edge has sampled `arb_bsy_n_i`=1.
- R8: Requester role: at the edge that samples `loc_req_i`=1 without a qualified grant, `arb_req_n_o` falls. A qualified grant means `arb_gnt_n_i`=0 and `arb_bsy_n_i`=1 at the same edge. At the first edge that samples a qualified grant, `loc_own_o` rises, `arb_bsy_n_o` falls and `arb_req_n_o` rises.
- R9: Requester role: a grant sampled while `arb_bsy_n_i`=0 gives no ownership, and the request stays low.
- R10: Requester role: if a qualified grant is already present at the edge that samples `loc_req_i`=1 (bus parked on this master), `loc_own_o` rises at that edge and `arb_req_n_o` never falls.
- R11: With no request on either side, ownership stays parked: `loc_own_o`=0 and all driven lines stay high.
- R12: `loc_own_o` and a low `arb_gnt_n_o` never occur together, and `loc_own_o`=1 always comes with `arb_bsy_n_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; rising edge is the only sampling and update edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_ext_i | input | 1 | Static role: 0 arbiter, 1 requester |
| loc_req_i | input | 1 | Local master wants the bus; held until ownership |
| loc_done_i | input | 1 | Local transfer finished; one-cycle pulse while owning |
| loc_own_o | output | 1 | Local master owns the bus and may start |
| arb_req_n_i | input | 1 | Sampled request line (arbiter role) |
| arb_req_n_o | output | 1 | Driven request line value (requester role) |
| arb_req_oe_o | output | 1 | Drive enable for the request line |
| arb_gnt_n_i | input | 1 | Sampled grant line (requester role) |
| arb_gnt_n_o | output | 1 | Driven grant line value (arbiter role) |
| arb_gnt_oe_o | output | 1 | Drive enable for the grant line |
| arb_bsy_n_i | input | 1 | Sampled busy line as seen on the bus |
| arb_bsy_n_o | output | 1 | Driven busy line value |
| arb_bsy_oe_o | output | 1 | Drive enable for the busy line |

## Verification
The hardest situation to reach is the tie-break hand-over in arbiter role. Both masters must request at one arbitration edge, the local tenure must end, and both must still be requesting when the bus frees up, so that the alternation rule is what picks the winner. Directed sequences build this case on purpose, along with a grant that is withdrawn and a grant that arrives while another master still holds busy. Random external-master and outside-arbiter agents then replay many other interleavings against a cycle model kept in the bench.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic [2:0] {
      ST_PARK    = 3'd0,
      ST_ASK     = 3'd1,
      ST_MINE    = 3'd2,
      ST_RELEASE = 3'd3,
      ST_OFFER   = 3'd4,
      ST_THEIRS  = 3'd5
   } bt_state_e;

   typedef struct packed {
      logic own;
      logic req_n;
      logic gnt_n;
      logic bsy_n;
      logic bsy_oe;
   } bt_side_t;

   localparam bt_side_t BT_SIDE_IDLE = '{own: 1'b0, req_n: 1'b1, gnt_n: 1'b1,
                                         bsy_n: 1'b1, bsy_oe: 1'b0};

   function automatic bt_side_t bt_decode(input bt_state_e st);
      bt_side_t s;
      s        = BT_SIDE_IDLE;
      s.own    = (st == ST_MINE);
      s.bsy_n  = (st != ST_MINE);
      s.bsy_oe = (st == ST_MINE) || (st == ST_RELEASE);
      s.req_n  = (st != ST_ASK);
      s.gnt_n  = (st != ST_OFFER);
      return s;
   endfunction

endpackage

// File: rtl/bt_int_arb.sv
module bt_int_arb
   import bt_pkg::*;
#(
   parameter bit TIE_ALTERNATE = 1'b1
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     en_i,
   input  logic     loc_req_i,
   input  logic     loc_done_i,
   input  logic     req_n_i,
   input  logic     bsy_n_i,
   output bt_side_t side_o
);

   bt_state_e st_q, st_d;
   logic      alt_q;
   logic      alt_set, alt_clr;
   logic      ext_req;

   assign ext_req = ~req_n_i;

   // fairness flag: variant chosen by parameter
   generate
      if (TIE_ALTERNATE) begin : g_alt
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      alt_q <= 1'b0;
            else if (!en_i)   alt_q <= 1'b0;
            else if (alt_clr) alt_q <= 1'b0;
            else if (alt_set) alt_q <= 1'b1;
         end
      end else begin : g_fixed
         assign alt_q = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      alt_set = 1'b0;
      alt_clr = 1'b0;
      unique case (st_q)
         ST_PARK: begin
            if (loc_req_i && !(ext_req && alt_q)) begin
               st_d    = ST_MINE;
               alt_set = ext_req;
            end else if (ext_req) begin
               st_d    = ST_OFFER;
               alt_clr = 1'b1;
            end
         end
         ST_MINE:    if (loc_done_i) st_d = ST_RELEASE;
         ST_RELEASE: if (bsy_n_i)    st_d = ST_PARK;
         ST_OFFER: begin
            if (!bsy_n_i)      st_d = ST_THEIRS;
            else if (!ext_req) st_d = ST_PARK;
         end
         ST_THEIRS:  if (bsy_n_i)    st_d = ST_PARK;
         default:                    st_d = ST_PARK;
      endcase
      if (!en_i) st_d = ST_PARK;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_PARK;
      else         st_q <= st_d;
   end

   assign side_o = bt_decode(st_q);

   // R3
   mine_drives_bsy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      side_o.own |-> (side_o.bsy_oe && !side_o.bsy_n));

   // R6
   done_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      (side_o.own && loc_done_i) |=> (!side_o.own && side_o.bsy_n && side_o.bsy_oe));

   // R4
   grant_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      (!side_o.gnt_n && !bsy_n_i) |=> side_o.gnt_n);

   // R7
   wait_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      ($rose(side_o.gnt_n) && !bsy_n_i) |=> (side_o.gnt_n && !side_o.own));

endmodule

// File: rtl/bt_ext_req.sv
module bt_ext_req
   import bt_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     en_i,
   input  logic     loc_req_i,
   input  logic     loc_done_i,
   input  logic     gnt_n_i,
   input  logic     bsy_n_i,
   output bt_side_t side_o
);

   bt_state_e st_q, st_d;
   logic      qual_gnt;

   assign qual_gnt = ~gnt_n_i & bsy_n_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_PARK: begin
            if (loc_req_i) st_d = qual_gnt ? ST_MINE : ST_ASK;
         end
         ST_ASK: begin
            if (qual_gnt)        st_d = ST_MINE;
            else if (!loc_req_i) st_d = ST_PARK;
         end
         ST_MINE:    if (loc_done_i) st_d = ST_RELEASE;
         ST_RELEASE: if (bsy_n_i)    st_d = ST_PARK;
         default:                    st_d = ST_PARK;
      endcase
      if (!en_i) st_d = ST_PARK;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_PARK;
      else         st_q <= st_d;
   end

   assign side_o = bt_decode(st_q);

   // R8
   grant_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      $rose(side_o.own) |-> $past(!gnt_n_i && bsy_n_i));

   // R8
   no_req_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      side_o.own |-> side_o.req_n);

   // R6
   ext_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
      (side_o.own && loc_done_i) |=> (!side_o.own && side_o.bsy_n));

endmodule

// File: rtl/bt_pin_mux.sv
module bt_pin_mux
   import bt_pkg::*;
#(
   parameter bit INT_EN = 1'b1,
   parameter bit EXT_EN = 1'b1
) (
   input  logic     mode_ext_i,
   input  bt_side_t int_side_i,
   input  bt_side_t ext_side_i,
   output bt_side_t side_o,
   output logic     req_oe_o,
   output logic     gnt_oe_o
);

   generate
      if (INT_EN && EXT_EN) begin : g_both
         assign side_o   = mode_ext_i ? ext_side_i : int_side_i;
         assign req_oe_o = mode_ext_i;
         assign gnt_oe_o = ~mode_ext_i;
      end else if (INT_EN) begin : g_int_only
         assign side_o   = int_side_i;
         assign req_oe_o = 1'b0;
         assign gnt_oe_o = 1'b1;
      end else begin : g_ext_only
         assign side_o   = ext_side_i;
         assign req_oe_o = 1'b1;
         assign gnt_oe_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
   import bt_pkg::*;
#(
   parameter bit INT_EN        = 1'b1,
   parameter bit EXT_EN        = 1'b1,
   parameter bit TIE_ALTERNATE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mode_ext_i,
   input  logic loc_req_i,
   input  logic loc_done_i,
   output logic loc_own_o,
   input  logic arb_req_n_i,
   output logic arb_req_n_o,
   output logic arb_req_oe_o,
   input  logic arb_gnt_n_i,
   output logic arb_gnt_n_o,
   output logic arb_gnt_oe_o,
   input  logic arb_bsy_n_i,
   output logic arb_bsy_n_o,
   output logic arb_bsy_oe_o
);

   localparam bit BOTH = INT_EN && EXT_EN;

   bt_side_t int_side, ext_side, sel_side;
   logic     int_en, ext_en;

   initial begin : p_param_chk
      assert (INT_EN || EXT_EN) else $error("bus_tenure_ctrl: no role enabled");
   end

   assign int_en = BOTH ? ~mode_ext_i : INT_EN;
   assign ext_en = BOTH ?  mode_ext_i : EXT_EN;

   generate
      if (INT_EN) begin : g_int
         bt_int_arb #(.TIE_ALTERNATE(TIE_ALTERNATE)) u_int (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (int_en),
            .loc_req_i  (loc_req_i),
            .loc_done_i (loc_done_i),
            .req_n_i    (arb_req_n_i),
            .bsy_n_i    (arb_bsy_n_i),
            .side_o     (int_side)
         );
      end else begin : g_no_int
         assign int_side = BT_SIDE_IDLE;
      end

      if (EXT_EN) begin : g_ext
         bt_ext_req u_ext (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (ext_en),
            .loc_req_i  (loc_req_i),
            .loc_done_i (loc_done_i),
            .gnt_n_i    (arb_gnt_n_i),
            .bsy_n_i    (arb_bsy_n_i),
            .side_o     (ext_side)
         );
      end else begin : g_no_ext
         assign ext_side = BT_SIDE_IDLE;
      end
   endgenerate

   bt_pin_mux #(.INT_EN(INT_EN), .EXT_EN(EXT_EN)) u_mux (
      .mode_ext_i (mode_ext_i),
      .int_side_i (int_side),
      .ext_side_i (ext_side),
      .side_o     (sel_side),
      .req_oe_o   (arb_req_oe_o),
      .gnt_oe_o   (arb_gnt_oe_o)
   );

   assign loc_own_o    = sel_side.own;
   assign arb_req_n_o  = sel_side.req_n;
   assign arb_gnt_n_o  = sel_side.gnt_n;
   assign arb_bsy_n_o  = sel_side.bsy_n;
   assign arb_bsy_oe_o = sel_side.bsy_oe;

   // R12
   own_vs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      loc_own_o |-> (arb_gnt_n_o && !arb_bsy_n_o));

   // R1
   reset_idle_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (!loc_own_o && arb_req_n_o && arb_gnt_n_o && !arb_bsy_oe_o));

endmodule

// File: tb/bus_tenure_ctrl_tb.sv
`timescale 1ns/1ps
module bus_tenure_ctrl_tb;

   localparam int M_PARK = 0, M_ASK = 1, M_MINE = 2, M_REL = 3, M_OFFER = 4, M_THEIRS = 5;

   logic clk = 1'b0;
   logic rst_n, mode_ext, loc_req, loc_done, req_n_in, gnt_n_in, oth_bsy_n;
   logic loc_own, req_n_out, req_oe, gnt_n_out, gnt_oe, bsy_n_out, bsy_oe;
   logic bus_bsy;

   int n_cmp = 0, n_bad = 0;
   int m_st, m_alt;
   logic s_lr, s_ld, s_rq, s_gn, s_bs;

   always #4 clk = ~clk;

   assign bus_bsy = (bsy_oe ? bsy_n_out : 1'b1) & oth_bsy_n;

   bus_tenure_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_ext_i(mode_ext),
      .loc_req_i(loc_req), .loc_done_i(loc_done), .loc_own_o(loc_own),
      .arb_req_n_i(req_n_in), .arb_req_n_o(req_n_out), .arb_req_oe_o(req_oe),
      .arb_gnt_n_i(gnt_n_in), .arb_gnt_n_o(gnt_n_out), .arb_gnt_oe_o(gnt_oe),
      .arb_bsy_n_i(bus_bsy), .arb_bsy_n_o(bsy_n_out), .arb_bsy_oe_o(bsy_oe)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_next(input int st, input int alt, input logic lr,
                                     input logic ld, input logic rq, input logic gn,
                                     input logic bs, input logic ext_mode);
      int n = st;
      if (!ext_mode) begin
         case (st)
            M_PARK:   if (lr && !(!rq && alt != 0)) n = M_MINE; else if (!rq) n = M_OFFER;
            M_MINE:   if (ld) n = M_REL;
            M_REL:    if (bs) n = M_PARK;
            M_OFFER:  if (!bs) n = M_THEIRS; else if (rq) n = M_PARK;
            M_THEIRS: if (bs) n = M_PARK;
            default:  n = M_PARK;
         endcase
      end else begin
         case (st)
            M_PARK:  if (lr) n = (!gn && bs) ? M_MINE : M_ASK;
            M_ASK:   if (!gn && bs) n = M_MINE; else if (!lr) n = M_PARK;
            M_MINE:  if (ld) n = M_REL;
            M_REL:   if (bs) n = M_PARK;
            default: n = M_PARK;
         endcase
      end
      return n;
   endfunction

   task automatic compare_all();
      chk("R3 own",   loc_own,   m_st == M_MINE);
      chk("R8 req",   req_n_out, m_st != M_ASK);
      chk("R4 gnt",   gnt_n_out, m_st != M_OFFER);
      chk("R6 bsy",   bsy_n_out, m_st != M_MINE);
      chk("R6 bsyoe", bsy_oe,    (m_st == M_MINE) || (m_st == M_REL));
      chk("R2 reqoe", req_oe,    mode_ext);
      chk("R2 gntoe", gnt_oe,    !mode_ext);
      chk("R12 excl", loc_own && !gnt_n_out, 1'b0);
   endtask

   task automatic cyc();
      int nx;
      #1;
      s_lr = loc_req; s_ld = loc_done; s_rq = req_n_in; s_gn = gnt_n_in; s_bs = bus_bsy;
      @(posedge clk);
      nx = model_next(m_st, m_alt, s_lr, s_ld, s_rq, s_gn, s_bs, mode_ext);
      if (!mode_ext && m_st == M_PARK) begin
         if (nx == M_MINE && !s_rq) m_alt = 1;
         else if (nx == M_OFFER) m_alt = 0;
      end
      m_st = nx;
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset(input logic md);
      rst_n = 1'b0; mode_ext = md; loc_req = 0; loc_done = 0;
      req_n_in = 1; gnt_n_in = 1; oth_bsy_n = 1;
      m_st = M_PARK; m_alt = 0;
      repeat (2) @(negedge clk);
      chk("R1 own",   loc_own,   1'b0);
      chk("R1 req",   req_n_out, 1'b1);
      chk("R1 gnt",   gnt_n_out, 1'b1);
      chk("R1 bsy",   bsy_n_out, 1'b1);
      chk("R1 bsyoe", bsy_oe,    1'b0);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int em_st, em_cnt, ob_cnt;
      void'($urandom(32'h5EED_0B05));

      // ---------------- arbiter role, directed ----------------
      do_reset(1'b0);
      chk("R2 gnt_oe", gnt_oe, 1'b1);
      chk("R2 req_oe", req_oe, 1'b0);
      repeat (3) cyc();
      chk("R11 own", loc_own, 1'b0);
      chk("R11 gnt", gnt_n_out, 1'b1);
      loc_req = 1; cyc();
      chk("R3 own", loc_own, 1'b1);
      chk("R3 bsy", bsy_n_out, 1'b0);
      loc_req = 0; loc_done = 1; cyc();
      chk("R6 own drop", loc_own, 1'b0);
      chk("R6 bsy high", bsy_n_out, 1'b1);
      chk("R6 oe held", bsy_oe, 1'b1);
      loc_done = 0; req_n_in = 0; cyc();
      chk("R6 no early grant", gnt_n_out, 1'b1);
      cyc();
      chk("R4 grant", gnt_n_out, 1'b0);
      cyc();
      chk("R4 grant held", gnt_n_out, 1'b0);
      oth_bsy_n = 0; req_n_in = 1; cyc();
      chk("R4 grant off", gnt_n_out, 1'b1);
      loc_req = 1; cyc();
      chk("R7 not owned while busy", loc_own, 1'b0);
      oth_bsy_n = 1; cyc();
      chk("R7 not before park", loc_own, 1'b0);
      cyc();
      chk("R7 owned after free", loc_own, 1'b1);
      loc_req = 0; loc_done = 1; cyc();
      loc_done = 0; cyc();
      // tie
      loc_req = 1; req_n_in = 0; cyc();
      chk("R5 local wins tie", loc_own, 1'b1);
      chk("R5 no grant on tie", gnt_n_out, 1'b1);
      loc_req = 0; loc_done = 1; cyc();
      loc_done = 0; loc_req = 1; cyc();
      cyc();
      chk("R5 external next", gnt_n_out, 1'b0);
      chk("R5 local waits", loc_own, 1'b0);
      oth_bsy_n = 0; req_n_in = 1; cyc();
      oth_bsy_n = 1; cyc();
      cyc();
      chk("R5 local after", loc_own, 1'b1);
      loc_req = 0; loc_done = 1; cyc();
      loc_done = 0; cyc();
      req_n_in = 0; cyc();
      chk("R4 offer", gnt_n_out, 1'b0);
      req_n_in = 1; cyc();
      chk("R4 withdraw", gnt_n_out, 1'b1);

      // ---------------- arbiter role, random ----------------
      em_st = 0; em_cnt = 0;
      for (int i = 0; i < 3000; i++) begin
         if (loc_own) begin
            loc_req = 0; loc_done = ($urandom % 3 == 0);
         end else begin
            loc_done = 0;
            if (!loc_req && $urandom % 4 == 0) loc_req = 1;
         end
         case (em_st)
            0: if ($urandom % 5 == 0) begin req_n_in = 0; em_st = 1; end
            1: if (!gnt_n_out && bus_bsy) begin
                  oth_bsy_n = 0; req_n_in = 1; em_cnt = 1 + $urandom % 4; em_st = 2;
               end else if ($urandom % 20 == 0) begin
                  req_n_in = 1; em_st = 0;
               end
            default: begin
               em_cnt--;
               if (em_cnt == 0) begin oth_bsy_n = 1; em_st = 0; end
            end
         endcase
         cyc();
      end

      // ---------------- requester role, directed ----------------
      do_reset(1'b1);
      chk("R2 req_oe ext", req_oe, 1'b1);
      chk("R2 gnt_oe ext", gnt_oe, 1'b0);
      loc_req = 1; cyc();
      chk("R8 request", req_n_out, 1'b0);
      chk("R8 not yet", loc_own, 1'b0);
      gnt_n_in = 0; oth_bsy_n = 0; cyc();
      chk("R9 busy blocks", loc_own, 1'b0);
      chk("R9 still asking", req_n_out, 1'b0);
      oth_bsy_n = 1; cyc();
      chk("R8 owned", loc_own, 1'b1);
      chk("R8 req off", req_n_out, 1'b1);
      chk("R8 bsy", bsy_n_out, 1'b0);
      loc_req = 0; gnt_n_in = 1; loc_done = 1; cyc();
      loc_done = 0; cyc();
      gnt_n_in = 0; loc_req = 1; cyc();
      chk("R10 parked own", loc_own, 1'b1);
      chk("R10 no request", req_n_out, 1'b1);
      loc_req = 0; loc_done = 1; cyc();
      loc_done = 0; gnt_n_in = 1; cyc();

      // ---------------- requester role, random ----------------
      ob_cnt = 0;
      for (int i = 0; i < 3000; i++) begin
         if (loc_own) begin
            loc_req = 0; loc_done = ($urandom % 3 == 0);
         end else begin
            loc_done = 0;
            if (!loc_req && $urandom % 4 == 0) loc_req = 1;
         end
         gnt_n_in = !((!req_n_out && $urandom % 3 == 0) || ($urandom % 6 == 0));
         if (ob_cnt > 0) begin
            ob_cnt--;
            if (ob_cnt == 0) oth_bsy_n = 1;
         end else if (!loc_own && $urandom % 8 == 0) begin
            oth_bsy_n = 0; ob_cnt = 1 + $urandom % 3;
         end
         cyc();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule